// File: doc/BRIEF.md
# Accumulator Harvard Microcontroller Core

This block is a compact multi-cycle processor core with separate program and data memories. It holds a 10-bit program counter, an 8-bit accumulator with a carry flag, an 8-bit index register, a zero flag and a single return-address register. It fetches 12-bit instruction words through a synchronous program-memory read port. It reaches data memory only through the index register, over a synchronous read/write port.

The two jump instructions are conditional calls. A taken jump saves the current PC in the return register. The return instruction loads an 8-bit constant into the accumulator while it restores the PC. A subroutine made only of return instructions therefore serves as a lookup table held in program memory. Each instruction runs a fetch cycle and an execute cycle. Instructions that read data memory add one further cycle. The memory ports are plain synchronous ports: an address driven in one cycle returns its data in the next, with no back-pressure.

Top module: `acc_harvard_core`

## Requirements
- R1: Every instruction starts with a fetch cycle that drives `pm_addr` with the PC, and `pm_rdata` is used one cycle later. Instructions that read data memory take 3 cycles and all others take 2. The PC changes only on the final cycle of an instruction.
- R2: The class is selected by bits [11:10]. Code 00 is jump-if-carry and 01 is jump-if-zero. When the tested flag is 1, the return register takes the current PC and the PC becomes bits [9:0] plus one. Otherwise only PC+1 happens.
- R3: Class 10 with bits [9:8] = 11 loads the accumulator with bits [7:0] and sets the PC to the return register plus one.
- R4: Class 10 with bits [9:8] = 00 loads the accumulator with bits [7:0] and clears carry. With bits [9:8] = 01, it computes A + imm + C, the accumulator keeps the low 8 bits and carry takes bit 8.
- R5: Class 10 with bits [9:8] = 10 adds bits [7:0] to the index register and leaves the accumulator and carry unchanged.
- R6: Class 11 with bits [9:7] = 000 loads the accumulator from data memory at the index address. Bits [9:7] = 001 store the accumulator there: `dm_we` is high for exactly one cycle, with `dm_addr` equal to the index register and `dm_wdata` equal to the accumulator.
- R7: Class 11 with bits [9:7] = 010 copies the accumulator to the index register. Bits [9:7] = 011 copy the index register to the accumulator.
- R8: Class 11 with bit 9 = 1 uses the data word at the index address as the operand. Bits [8:7] = 00 give A + M + C, with carry from bit 8. Bits [8:7] = 01 give A − M − C, with carry set on underflow.
- R9: With bits [8:7] = 10 the core computes A AND M, and with 11 it computes NOR(A, M). Both clear carry.
- R10: After every instruction, the zero flag equals 1 exactly when the accumulator is zero.
- R11: In class 11, instruction bits [6:0] have no effect.
- R12: While reset is low, the PC, accumulator, index register, flags, return register and sequencer are cleared, `pm_addr` is 0 and `dm_we` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pm_addr | output | 10 | Program memory read address (the PC) |
| pm_rdata | input | 12 | Program word, valid the cycle after its address |
| dm_addr | output | 8 | Data memory address (the index register) |
| dm_rdata | input | 8 | Data word, valid the cycle after its address |
| dm_wdata | output | 8 | Store data (the accumulator) |
| dm_we | output | 1 | Data memory write enable |

## Verification
Three updates land in the same commit cycle of a taken jump: the return register saves the old PC, the PC is redirected and the PC is incremented. On a return, the accumulator load and the PC restore likewise coincide. Directed call/return and lookup sequences provoke these collisions, and seeded random programs with dense jumps and stores add more. The bench judges each run by the list of stores it observes, each with its address, data and exact cycle. It compares that list with an instruction-level model written from the requirements.

// File: rtl/acc_core_pkg.sv
package acc_core_pkg;
  typedef enum logic [1:0] {ST_FETCH, ST_EXEC, ST_MEM} seq_t;

  typedef enum logic [3:0] {
    OP_JC, OP_JZ, OP_LDI, OP_ADCI, OP_ADXI, OP_RETI, OP_LDM,
    OP_STM, OP_TAX, OP_TXA, OP_ADDM, OP_SUBM, OP_ANDM, OP_NORM
  } op_t;

  typedef enum logic [1:0] {FN_ADD, FN_SUB, FN_AND, FN_NOR} alu_fn_t;
endpackage

// File: rtl/acc_decode.sv
module acc_decode
  import acc_core_pkg::*;
#(
  parameter int IW = 12
) (
  input  logic [IW-1:0] instr,
  output op_t           op,
  output logic          mem_rd
);
  localparam int CB = IW - 1;

  always_comb begin
    op = OP_JC;
    unique case (instr[CB -: 2])
      2'b00: op = OP_JC;
      2'b01: op = OP_JZ;
      2'b10: begin
        unique case (instr[CB-2 -: 2])
          2'b00: op = OP_LDI;
          2'b01: op = OP_ADCI;
          2'b10: op = OP_ADXI;
          default: op = OP_RETI;
        endcase
      end
      default: begin
        if (instr[CB-2]) begin
          unique case (instr[CB-3 -: 2])
            2'b00: op = OP_ADDM;
            2'b01: op = OP_SUBM;
            2'b10: op = OP_ANDM;
            default: op = OP_NORM;
          endcase
        end else begin
          unique case (instr[CB-3 -: 2])
            2'b00: op = OP_LDM;
            2'b01: op = OP_STM;
            2'b10: op = OP_TAX;
            default: op = OP_TXA;
          endcase
        end
      end
    endcase
  end

  assign mem_rd = (op == OP_LDM) || (op == OP_ADDM) || (op == OP_SUBM) ||
                  (op == OP_ANDM) || (op == OP_NORM);
endmodule

// File: rtl/acc_alu.sv
module acc_alu
  import acc_core_pkg::*;
#(
  parameter int DW = 8
) (
  input  alu_fn_t       fn,
  input  logic [DW-1:0] a,
  input  logic [DW-1:0] b,
  input  logic          cin,
  output logic [DW-1:0] res,
  output logic          cout
);
  logic [DW:0] sum_w;
  logic [DW:0] dif_w;

  always_comb begin
    sum_w = {1'b0, a} + {1'b0, b} + {{DW{1'b0}}, cin};
    dif_w = {1'b0, a} - {1'b0, b} - {{DW{1'b0}}, cin};
    unique case (fn)
      FN_ADD: begin res = sum_w[DW-1:0]; cout = sum_w[DW]; end
      FN_SUB: begin res = dif_w[DW-1:0]; cout = dif_w[DW]; end
      FN_AND: begin res = a & b;         cout = 1'b0;      end
      default: begin res = ~(a | b);     cout = 1'b0;      end
    endcase
  end
endmodule

// File: rtl/acc_harvard_core.sv
module acc_harvard_core
  import acc_core_pkg::*;
#(
  parameter int PC_W = 10,
  parameter int DW   = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  output logic [PC_W-1:0] pm_addr,
  input  logic [PC_W+1:0] pm_rdata,
  output logic [DW-1:0]   dm_addr,
  input  logic [DW-1:0]   dm_rdata,
  output logic [DW-1:0]   dm_wdata,
  output logic            dm_we
);
  localparam int IW = PC_W + 2;

  seq_t            state;
  logic [PC_W-1:0] pc, rr;
  logic [DW-1:0]   acc, ix;
  logic            cf, zf;
  logic [IW-1:0]   instr_q;

  logic [IW-1:0]   cur;
  op_t             op;
  logic            mem_rd;
  logic            done;
  alu_fn_t         fn;
  logic [DW-1:0]   alu_b, alu_res, imm;
  logic            alu_cout;
  logic [PC_W-1:0] pc_n, rr_n;
  logic [DW-1:0]   acc_n, ix_n;
  logic            cf_n;

  assign cur = (state == ST_EXEC) ? pm_rdata : instr_q;
  assign imm = cur[DW-1:0];

  acc_decode #(.IW(IW)) u_dec (.instr(cur), .op(op), .mem_rd(mem_rd));

  always_comb begin
    unique case (op)
      OP_SUBM: fn = FN_SUB;
      OP_ANDM: fn = FN_AND;
      OP_NORM: fn = FN_NOR;
      default: fn = FN_ADD;
    endcase
    alu_b = (op == OP_ADCI) ? imm : dm_rdata;
  end

  acc_alu #(.DW(DW)) u_alu (
    .fn(fn), .a(acc), .b(alu_b), .cin(cf), .res(alu_res), .cout(alu_cout)
  );

  assign done = ((state == ST_EXEC) && !mem_rd) || (state == ST_MEM);

  always_comb begin
    pc_n  = pc + PC_W'(1);
    rr_n  = rr;
    acc_n = acc;
    ix_n  = ix;
    cf_n  = cf;
    unique case (op)
      OP_JC, OP_JZ: begin
        if ((op == OP_JC) ? cf : zf) begin
          rr_n = pc;
          pc_n = cur[PC_W-1:0] + PC_W'(1);
        end
      end
      OP_LDI:  begin acc_n = imm; cf_n = 1'b0; end
      OP_ADXI: ix_n = ix + imm;
      OP_RETI: begin acc_n = imm; pc_n = rr + PC_W'(1); end
      OP_LDM:  acc_n = dm_rdata;
      OP_TAX:  ix_n = acc;
      OP_TXA:  acc_n = ix;
      OP_STM:  ;
      default: begin acc_n = alu_res; cf_n = alu_cout; end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= ST_FETCH;
      pc      <= '0;
      rr      <= '0;
      acc     <= '0;
      ix      <= '0;
      cf      <= 1'b0;
      zf      <= 1'b0;
      instr_q <= '0;
    end else begin
      unique case (state)
        ST_FETCH: state <= ST_EXEC;
        ST_EXEC: begin
          instr_q <= pm_rdata;
          state   <= mem_rd ? ST_MEM : ST_FETCH;
        end
        default: state <= ST_FETCH;
      endcase
      if (done) begin
        pc  <= pc_n;
        rr  <= rr_n;
        acc <= acc_n;
        ix  <= ix_n;
        cf  <= cf_n;
        zf  <= (acc_n == '0);
      end
    end
  end

  assign pm_addr  = pc;
  assign dm_addr  = ix;
  assign dm_wdata = acc;
  assign dm_we    = (state == ST_EXEC) && (op == OP_STM);

  AST_FETCH_THEN_EXEC: assert property (@(posedge clk) disable iff (!rst_n)
    state == ST_FETCH |=> state == ST_EXEC); // R1
  AST_PC_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !done |=> $stable(pc)); // R1
  AST_UNTAKEN_JC: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_EXEC && op == OP_JC && !cf) |=> pc == $past(pc) + PC_W'(1)); // R2
  AST_RET_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
    (done && op == OP_RETI) |=> pc == $past(rr) + PC_W'(1)); // R3
  AST_WE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    dm_we |=> !dm_we); // R6
  AST_ZERO_TRACKS: assert property (@(posedge clk) disable iff (!rst_n)
    $past(done) |-> zf == (acc == '0)); // R10
endmodule

// File: tb/acc_harvard_core_bench.sv
module acc_harvard_core_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [9:0]  pm_addr;
  logic [11:0] pm_rdata;
  logic [7:0]  dm_addr, dm_rdata, dm_wdata;
  logic        dm_we;

  logic [11:0] pm [1024];
  logic [7:0]  dm [256];
  logic [7:0]  dm_init [256];
  logic [7:0]  ref_dm [256];

  int exp_cyc [512]; int exp_adr [512]; int exp_dat [512]; int exp_n;
  int got_cyc [512]; int got_adr [512]; int got_dat [512]; int got_n;
  int cyc, t_end;
  int n_tests = 0, n_fail = 0;
  int total_cyc = 0;

  always #5 clk = ~clk;

  acc_harvard_core u_acc_harvard_core (
    .clk(clk), .rst_n(rst_n), .pm_addr(pm_addr), .pm_rdata(pm_rdata),
    .dm_addr(dm_addr), .dm_rdata(dm_rdata), .dm_wdata(dm_wdata), .dm_we(dm_we)
  );

  always @(posedge clk) begin
    pm_rdata <= pm[pm_addr];
    dm_rdata <= dm[dm_addr];
    if (!rst_n) begin
      for (int i = 0; i < 256; i++) dm[i] <= dm_init[i];
    end else if (dm_we) begin
      dm[dm_addr] <= dm_wdata;
    end
  end

  always @(posedge clk) begin
    total_cyc <= total_cyc + 1;
    if (!rst_n) cyc <= 0; else cyc <= cyc + 1;
  end

  always @(negedge clk) begin
    if (rst_n && dm_we && got_n < 512) begin
      got_cyc[got_n] = cyc;
      got_adr[got_n] = int'(dm_addr);
      got_dat[got_n] = int'(dm_wdata);
      got_n = got_n + 1;
    end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // Instruction-level model built from the requirements
  task automatic model_run(input int n_instr);
    logic [9:0] pc, rr;
    logic [7:0] acc, ix, imm, m;
    logic       c, z, rd;
    logic [8:0] t9;
    logic [11:0] w;
    int t;
    pc = '0; rr = '0; acc = '0; ix = '0; c = 1'b0; z = 1'b0; t = 0; exp_n = 0;
    for (int i = 0; i < 256; i++) ref_dm[i] = dm_init[i];
    for (int k = 0; k < n_instr; k++) begin
      w = pm[pc]; imm = w[7:0]; rd = 1'b0;
      case (w[11:10])
        2'b00: if (c) begin rr = pc; pc = w[9:0]; end
        2'b01: if (z) begin rr = pc; pc = w[9:0]; end
        2'b10: case (w[9:8])
          2'b00: begin acc = imm; c = 1'b0; end
          2'b01: begin t9 = {1'b0, acc} + {1'b0, imm} + {8'd0, c}; acc = t9[7:0]; c = t9[8]; end
          2'b10: ix = ix + imm;
          default: begin acc = imm; pc = rr; end
        endcase
        default: begin
          if (w[9]) begin
            rd = 1'b1; m = ref_dm[ix];
            case (w[8:7])
              2'b00: begin t9 = {1'b0, acc} + {1'b0, m} + {8'd0, c}; acc = t9[7:0]; c = t9[8]; end
              2'b01: begin t9 = {1'b0, acc} - {1'b0, m} - {8'd0, c}; acc = t9[7:0]; c = t9[8]; end
              2'b10: begin acc = acc & m; c = 1'b0; end
              default: begin acc = ~(acc | m); c = 1'b0; end
            endcase
          end else if (w[8]) begin
            if (w[7]) acc = ix; else ix = acc;
          end else if (w[7]) begin
            if (exp_n < 512) begin
              exp_cyc[exp_n] = t + 1; exp_adr[exp_n] = int'(ix); exp_dat[exp_n] = int'(acc);
              exp_n++;
            end
            ref_dm[ix] = acc;
          end else begin
            rd = 1'b1; acc = ref_dm[ix];
          end
        end
      endcase
      pc = pc + 10'd1;
      z = (acc == 8'd0);
      t = t + (rd ? 3 : 2);
    end
    t_end = t;
  endtask

  task automatic run_prog(input int n_instr, input string name);
    model_run(n_instr);
    rst_n = 1'b0;
    got_n = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(pm_addr == 10'd0, "R12", {name, " reset pm_addr"}, int'(pm_addr), 0);
    check(dm_we == 1'b0, "R12", {name, " reset dm_we"}, int'(dm_we), 0);
    got_n = 0;
    rst_n = 1'b1;
    repeat (t_end) @(posedge clk);
    @(negedge clk);
    check(got_n == exp_n, "R1", {name, " store count"}, got_n, exp_n);
    for (int i = 0; i < exp_n && i < got_n; i++) begin
      check(got_cyc[i] == exp_cyc[i], "R1", {name, " store cycle"}, got_cyc[i], exp_cyc[i]);
      check(got_adr[i] == exp_adr[i], "R6", {name, " store addr"}, got_adr[i], exp_adr[i]);
      check(got_dat[i] == exp_dat[i], "R6", {name, " store data"}, got_dat[i], exp_dat[i]);
    end
  endtask

  task automatic want(input int i, input int c, input int a, input int d, input string req);
    check(got_n > i, req, "store present", got_n, i + 1);
    if (got_n > i) begin
      check(got_cyc[i] == c, req, "hand store cycle", got_cyc[i], c);
      check(got_adr[i] == a, req, "hand store addr", got_adr[i], a);
      check(got_dat[i] == d, req, "hand store data", got_dat[i], d);
    end
  endtask

  task automatic clear_mem();
    for (int i = 0; i < 1024; i++) pm[i] = 12'h000;
    for (int i = 0; i < 256; i++) dm_init[i] = 8'h00;
  endtask

  initial begin
    int r;
    logic [11:0] w;
    void'($urandom(32'd20011107));

    // Directed A: call, lookup return, carry jump, junk bits
    clear_mem();
    pm[0] = 12'h855; pm[1] = 12'hD00; pm[2] = 12'h8AA; pm[3] = 12'hC80;
    pm[4] = 12'h8FF; pm[5] = 12'h901; pm[6] = 12'h00F; pm[7] = 12'hC80;
    pm[8] = 12'hDDA; pm[9] = 12'hCB3; pm[10] = 12'h800; pm[11] = 12'h40A;
    pm[16] = 12'hC80; pm[17] = 12'hB99;
    run_prog(30, "dirA");
    want(0, 7, 8'h55, 8'hAA, "R7");   // TAX then store at index
    want(1, 15, 8'h55, 8'h00, "R4");  // ADC overflow sets carry, JC taken (R2)
    want(2, 19, 8'h55, 8'h99, "R3");  // return loads constant, resumes after jump
    want(3, 23, 8'h55, 8'h55, "R11"); // junk low bits on TXA and store

    // Directed B: memory ALU ops, index add, zero-flag jumps
    clear_mem();
    dm_init[16] = 8'h05;
    pm[0] = 12'h810; pm[1] = 12'hD00; pm[2] = 12'h803; pm[3] = 12'hE80;
    pm[4] = 12'hC80; pm[5] = 12'hE00; pm[6] = 12'hC80; pm[7] = 12'hF80;
    pm[8] = 12'h900; pm[9] = 12'hC80; pm[10] = 12'hF00; pm[11] = 12'hA01;
    pm[12] = 12'hC80; pm[13] = 12'h801; pm[14] = 12'h41F; pm[15] = 12'hC80;
    pm[16] = 12'h800; pm[17] = 12'h41F;
    pm[32] = 12'hC80; pm[33] = 12'h800; pm[34] = 12'h421;
    run_prog(40, "dirB");
    want(0, 10, 8'h10, 8'hFE, "R8");  // 3 - 5 borrows
    want(1, 15, 8'h10, 8'hFD, "R8");  // FE + FE + carry
    want(2, 22, 8'h10, 8'h02, "R9");  // NOR then ADC shows carry cleared
    want(3, 29, 8'h11, 8'h02, "R5");  // index add, accumulator kept
    want(4, 35, 8'h11, 8'h01, "R2");  // JZ not taken
    want(5, 41, 8'h11, 8'h00, "R10"); // zero flag set, JZ taken

    // Random programs
    for (int p = 0; p < 6; p++) begin
      for (int i = 0; i < 256; i++) dm_init[i] = 8'($urandom);
      for (int i = 0; i < 1024; i++) begin
        r = int'($urandom);
        w = r[11:0];
        if (r[15:14] == 2'b00) w = 12'hC80 | {5'd0, w[6:0]};
        if (w[11] == 1'b0) w[9:6] = 4'd0;
        pm[i] = w;
      end
      run_prog(300, "rand");
    end

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    wait (total_cyc >= 150000);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog: actual %0d expected below %0d", total_cyc, 150000);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule